// File: doc/BRIEF.md
# Protected I/O Chip-Select Decoder

This block maps up to four external byte-wide peripherals into the host I/O address space. Each peripheral occupies a window of four consecutive ports. For every select the block holds a base address, and selects 1 to 3 also hold a disable flag. Software writes these through a small byte-wide register port. During a valid host I/O cycle, the host address is compared against every enabled window. The block then drives the chip select of the winning window at that select's own polarity. The two lowest address bits go straight to the peripherals' address lines.

Boot firmware sets up the windows and then sets a lock flag. The lock can only be set, never cleared by software. It freezes the base and disable settings of selects 1 to 3 until the next reset. Select 0 never locks and can never be disabled, so it stays free for watching a diagnostic port such as 80h. Select 1 is active high, for a display controller; the others are active low. Protocol decoding, the data path and strobe timing are handled elsewhere.

Top module: `iocs_decoder`

## Requirements
- R1: After reset every base is 0, selects 1 to 3 are disabled, the lock is clear, and select 0 is enabled.
- R2: A select is active when `io_valid` is high, `io_addr[15:2]` equals its base, and it is enabled. `io_addr[1:0]` plays no part in the match. A base is built from two bytes: the high byte gives address bits [15:8], and bits [7:2] of the low byte give address bits [7:2].
- R3: While `io_valid` is low, no select is active.
- R4: Select 1 is driven high when active and low when idle. Selects 0, 2 and 3 are driven low when active and high when idle.
- R5: Bit 0 of the low byte of selects 1 to 3 is the disable flag (1 = disabled). A disabled select never becomes active.
- R6: Writing 1 to bit 1 of the low byte of any of selects 1 to 3 sets the shared lock. Once the lock is set, every write to either byte of selects 1 to 3 is ignored, and writing 0 to the lock bit has no effect. Only reset clears the lock.
- R7: Select 0 is never locked. Its low-byte bits [1:0] read as 0, and writes to them are ignored.
- R8: When enabled windows overlap, only the lowest-numbered matching select is active.
- R9: `xa_o` always equals `io_addr[1:0]`.
- R10: Register address bit 0 picks the byte (1 = high, 0 = low), and bits [2:1] pick the select. A read returns the current contents whether or not the lock is set. In the low byte of selects 1 to 3, bit 1 reads back the lock.
- R11: A register write takes effect at the next rising clock edge. Decoding is combinational from the stored settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or platform bus reset) |
| io_valid | input | 1 | Host I/O cycle qualifier |
| io_addr | input | ADDR_W | Host I/O address |
| cfg_we | input | 1 | Register write enable |
| cfg_waddr | input | SEL_W+1 | Write register address {select, byte} |
| cfg_wdata | input | 8 | Write data |
| cfg_raddr | input | SEL_W+1 | Read register address {select, byte} |
| cfg_rdata | output | 8 | Read data |
| cs_o | output | NUM_SEL | Chip selects at their physical polarity |
| xa_o | output | 2 | Low address lines to peripherals |

## Verification
The bench builds the block with its defaults: four selects, a 16-bit address, and select 1 as the only active-high output. With these values, overlapping windows and the full polarity mix can be reached. The random phase mostly aims addresses at the configured bases, so matches, overlaps and disabled hits come up often and not only by chance. Directed steps then set the lock. They confirm that later writes to selects 1 to 3 are ignored, that select 0 stays writable, and that clearing the lock bit has no effect.

// File: rtl/iocs_pkg.sv
package iocs_pkg;
    localparam int SUB_W = 2;           // address bits inside one window
    localparam int BYTE_W = 8;
    localparam int DIS_BIT = 0;         // disable flag position in low byte
    localparam int LOCK_BIT = 1;        // lock flag position in low byte

    typedef enum logic {
        BYTE_LO = 1'b0,
        BYTE_HI = 1'b1
    } reg_byte_e;
endpackage

// File: rtl/iocs_cfg_regs.sv
module iocs_cfg_regs
    import iocs_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int ADDR_W  = 16,
    localparam int SEL_W  = $clog2(NUM_SEL),
    localparam int BASE_W = ADDR_W - SUB_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [SEL_W:0]                  wr_addr,
    input  logic [BYTE_W-1:0]               wr_data,
    input  logic [SEL_W:0]                  rd_addr,
    output logic [BYTE_W-1:0]               rd_data,
    output logic [NUM_SEL-1:0][BASE_W-1:0]  base_o,
    output logic [NUM_SEL-1:0]              dis_o,
    output logic                            lock_o
);
    localparam int LO_W = BYTE_W - SUB_W;

    typedef struct packed {
        logic [NUM_SEL-1:0][BASE_W-1:0] base;
        logic [NUM_SEL-1:0]             dis;
        logic                           lock;
    } cfg_t;

    cfg_t            cfg_d, cfg_q;
    logic [SEL_W-1:0] wsel, rsel;
    reg_byte_e       wbyte, rbyte;
    logic            wprot;

    always_comb begin
        cfg_d = cfg_q;
        wsel  = wr_addr[SEL_W:1];
        wbyte = reg_byte_e'(wr_addr[0]);
        wprot = (wsel != '0);
        if (wr_en && !(wprot && cfg_q.lock)) begin
            if (wbyte == BYTE_HI) begin
                cfg_d.base[wsel][BASE_W-1:LO_W] = wr_data;
            end else begin
                cfg_d.base[wsel][LO_W-1:0] = wr_data[BYTE_W-1:SUB_W];
                if (wprot) begin
                    cfg_d.dis[wsel] = wr_data[DIS_BIT];
                    if (wr_data[LOCK_BIT]) cfg_d.lock = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.base <= '0;
            cfg_q.dis  <= {{(NUM_SEL-1){1'b1}}, 1'b0};
            cfg_q.lock <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rsel  = rd_addr[SEL_W:1];
        rbyte = reg_byte_e'(rd_addr[0]);
        if (rbyte == BYTE_HI) begin
            rd_data = cfg_q.base[rsel][BASE_W-1:LO_W];
        end else if (rsel == '0) begin
            rd_data = {cfg_q.base[rsel][LO_W-1:0], 2'b00};
        end else begin
            rd_data = {cfg_q.base[rsel][LO_W-1:0], cfg_q.lock, cfg_q.dis[rsel]};
        end
    end

    assign base_o = cfg_q.base;
    assign dis_o  = cfg_q.dis;
    assign lock_o = cfg_q.lock;
endmodule

// File: rtl/iocs_win_match.sv
module iocs_win_match
    import iocs_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int ADDR_W  = 16,
    localparam int BASE_W = ADDR_W - SUB_W
) (
    input  logic                           valid,
    input  logic [BASE_W-1:0]              addr_hi,
    input  logic [NUM_SEL-1:0][BASE_W-1:0] base,
    input  logic [NUM_SEL-1:0]             dis,
    output logic [NUM_SEL-1:0]             hit
);
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_win
        assign hit[i] = valid && (addr_hi == base[i]) && !dis[i];
    end
endmodule

// File: rtl/iocs_prio_drive.sv
module iocs_prio_drive #(
    parameter int NUM_SEL = 4,
    parameter logic [NUM_SEL-1:0] ACT_HIGH = 4'b0010
) (
    input  logic [NUM_SEL-1:0] hit,
    output logic [NUM_SEL-1:0] cs
);
    logic [NUM_SEL-1:0] grant;
    logic               taken;

    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < NUM_SEL; i++) begin
            if (hit[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_pol
        if (ACT_HIGH[i]) begin : g_hi
            assign cs[i] = grant[i];
        end else begin : g_lo
            assign cs[i] = ~grant[i];
        end
    end
endmodule

// File: rtl/iocs_decoder.sv
module iocs_decoder
    import iocs_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int ADDR_W  = 16,
    parameter logic [NUM_SEL-1:0] ACT_HIGH = 4'b0010,
    localparam int SEL_W  = $clog2(NUM_SEL),
    localparam int BASE_W = ADDR_W - SUB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_valid,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               cfg_we,
    input  logic [SEL_W:0]     cfg_waddr,
    input  logic [7:0]         cfg_wdata,
    input  logic [SEL_W:0]     cfg_raddr,
    output logic [7:0]         cfg_rdata,
    output logic [NUM_SEL-1:0] cs_o,
    output logic [SUB_W-1:0]   xa_o
);
    logic [NUM_SEL-1:0][BASE_W-1:0] base_w;
    logic [NUM_SEL-1:0]             dis_w;
    logic                           lock_w;
    logic [NUM_SEL-1:0]             hit_w;

    iocs_cfg_regs #(.NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_addr(cfg_waddr), .wr_data(cfg_wdata),
        .rd_addr(cfg_raddr), .rd_data(cfg_rdata),
        .base_o(base_w), .dis_o(dis_w), .lock_o(lock_w)
    );

    iocs_win_match #(.NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W)) i_match (
        .valid(io_valid), .addr_hi(io_addr[ADDR_W-1:SUB_W]),
        .base(base_w), .dis(dis_w), .hit(hit_w)
    );

    iocs_prio_drive #(.NUM_SEL(NUM_SEL), .ACT_HIGH(ACT_HIGH)) i_prio (
        .hit(hit_w), .cs(cs_o)
    );

    assign xa_o = io_addr[SUB_W-1:0];
endmodule

// File: rtl/iocs_decoder_chk.sv
module iocs_decoder_chk
    import iocs_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int ADDR_W  = 16,
    parameter logic [NUM_SEL-1:0] ACT_HIGH = 4'b0010,
    localparam int SEL_W  = $clog2(NUM_SEL),
    localparam int BASE_W = ADDR_W - SUB_W,
    localparam int LO_W   = BYTE_W - SUB_W
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           io_valid,
    input logic                           cfg_we,
    input logic [SEL_W:0]                 cfg_waddr,
    input logic [7:0]                     cfg_wdata,
    input logic [NUM_SEL-1:0]             cs_o,
    input logic [NUM_SEL-1:0][BASE_W-1:0] base_w,
    input logic [NUM_SEL-1:0]             dis_w,
    input logic                           lock_w
);
    logic [NUM_SEL-1:0] act;
    assign act = cs_o ^ ~ACT_HIGH;

    // R3
    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_valid |-> (act == '0));

    // R8
    p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act));

    // R5
    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_w & act) == '0);

    // R6
    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_w |=> lock_w);

    // R6
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_w |=> ($stable(base_w[NUM_SEL-1:1]) && $stable(dis_w)));

    // R7
    p_sel0_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_waddr == {{SEL_W{1'b0}}, 1'b1})
        |=> (base_w[0][BASE_W-1:LO_W] == $past(cfg_wdata)));
endmodule

bind iocs_decoder iocs_decoder_chk #(
    .NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W), .ACT_HIGH(ACT_HIGH)
) i_chk (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cs_o(cs_o), .base_w(base_w), .dis_w(dis_w), .lock_w(lock_w)
);

// File: tb/test_iocs_decoder.sv
module test_iocs_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_waddr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [2:0]  cfg_raddr = '0;
    logic [7:0]  cfg_rdata;
    logic [3:0]  cs_o;
    logic [1:0]  xa_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [13:0] mbase [4];
    logic [3:0]  mdis;
    logic        mlock;

    always #2 clk = ~clk;

    iocs_decoder i_iocs_decoder (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_addr(io_addr),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .cs_o(cs_o), .xa_o(xa_o)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] exp_cs(input logic v, input logic [15:0] a);
        logic [3:0] g = '0;
        for (int i = 0; i < 4; i++)
            if (g == '0 && v && a[15:2] == mbase[i] && !mdis[i]) g[i] = 1'b1;
        return ~(g ^ 4'b0010);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [2:0] ra);
        int s = int'(ra[2:1]);
        if (ra[0]) return mbase[s][13:6];
        if (s == 0) return {mbase[0][5:0], 2'b00};
        return {mbase[s][5:0], mlock, mdis[s]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) mbase[i] = '0;
        mdis = 4'b1110;
        mlock = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        int s = int'(a[2:1]);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!(s != 0 && mlock)) begin
            if (a[0]) mbase[s][13:6] = d;
            else begin
                mbase[s][5:0] = d[7:2];
                if (s != 0) begin
                    mdis[s] = d[0];
                    if (d[1]) mlock = 1'b1;
                end
            end
        end
    endtask

    task automatic rd_check(input string tag, input logic [2:0] a);
        cfg_raddr = a;
        #1;
        check(tag, {8'h0, cfg_rdata}, {8'h0, exp_rd(a)});
    endtask

    task automatic dec_check(input string tag, input logic v, input logic [15:0] a);
        io_valid = v; io_addr = a;
        #1;
        check(tag, {12'h0, cs_o}, {12'h0, exp_cs(v, a)});
        check("R9 xa", {14'h0, xa_o}, {14'h0, a[1:0]});
    endtask

    task automatic set_base(input logic [2:0] s, input logic [15:0] b, input logic [1:0] flags);
        wr({s[1:0], 1'b1}, b[15:8]);
        wr({s[1:0], 1'b0}, {b[7:2], flags});
    endtask

    task automatic random_phase(input int n, input bit allow_lock);
        for (int it = 0; it < n; it++) begin
            int op = int'($urandom % 5);
            @(negedge clk);
            if (op == 0) begin
                logic [7:0] d = 8'($urandom);
                if (!allow_lock) d[1] = 1'b0;
                wr(3'($urandom), d);
            end else if (op == 1) begin
                rd_check("R10 random read", 3'($urandom));
            end else begin
                int k = int'($urandom % 4);
                logic [15:0] a = ($urandom % 3 == 0) ? 16'($urandom)
                                 : {mbase[k], 2'($urandom)};
                dec_check("R2/R8 random decode", ($urandom % 6) != 0, a);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1c05));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) rd_check("R1 reset read", 3'(a));
        dec_check("R1 sel0 enabled at reset", 1'b1, 16'h0002);

        // R2, R8: overlap, lowest wins
        set_base(3'd0, 16'h0080, 2'b00);
        set_base(3'd1, 16'h0300, 2'b00);
        set_base(3'd2, 16'h0300, 2'b00);
        set_base(3'd3, 16'h02F8, 2'b00);
        dec_check("R8 overlap sel1 wins", 1'b1, 16'h0301);
        check("R4 sel1 active high", {15'h0, cs_o[1]}, 16'h1);
        dec_check("R2 sel3 window top", 1'b1, 16'h02FB);
        check("R4 sel3 active low", {15'h0, cs_o[3]}, 16'h0);
        dec_check("R2 one above window", 1'b1, 16'h02FC);
        dec_check("R2 port 80 snoop", 1'b1, 16'h0083);
        dec_check("R3 no valid", 1'b0, 16'h0301);
        check("R3 idle levels", {12'h0, cs_o}, 16'h000D);

        // R5: disable sel1, sel2 takes over
        set_base(3'd1, 16'h0300, 2'b01);
        dec_check("R5 disabled sel1", 1'b1, 16'h0302);
        rd_check("R10 low byte with disable", 3'b010);

        random_phase(300, 1'b0);

        // R6: lock and freeze
        set_base(3'd1, 16'h0300, 2'b01);
        set_base(3'd2, 16'h0300, 2'b00);
        wr(3'b110, 8'h02 | {mbase[3][5:0], 2'b00});
        rd_check("R6 lock reads back", 3'b110);
        wr(3'b011, 8'hA5);
        rd_check("R6 high byte frozen", 3'b011);
        check("R6 sel1 base kept", {8'h0, cfg_rdata}, 16'h0003);
        wr(3'b010, 8'h00);
        rd_check("R6 clear attempt ignored", 3'b010);
        check("R6 lock still set", {15'h0, cfg_rdata[1]}, 16'h1);
        dec_check("R6 decode after lock", 1'b1, 16'h0300);

        // R7: sel0 stays writable, low bits read zero
        wr(3'b001, 8'h12);
        wr(3'b000, 8'h37);
        rd_check("R7 sel0 high after lock", 3'b001);
        rd_check("R7 sel0 low bits zero", 3'b000);
        check("R7 sel0 low literal", {8'h0, cfg_rdata}, 16'h0034);
        dec_check("R7 sel0 new window", 1'b1, 16'h1236);

        // R11: write visible only after the edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = 3'b001; cfg_wdata = 8'h44; cfg_raddr = 3'b001;
        #1;
        check("R11 before edge", {8'h0, cfg_rdata}, 16'h0012);
        @(negedge clk);
        cfg_we = 1'b0;
        mbase[0][13:6] = 8'h44;
        #1;
        check("R11 after edge", {8'h0, cfg_rdata}, 16'h0044);

        random_phase(200, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired got=running expected=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule